// File: doc/BRIEF.md
# Configurable fault response manager

This block gathers fault detections from the protection sources of a motor drive and decides how the gate stage reacts. The sources are a set of lock and current-limit detectors, a dry-run detector, a bus CRC error, a watchdog timeout, and a supply overvoltage and a supply undervoltage comparator. Each source has its own response setting. That setting selects whether the source is ignored, only reported, recovered automatically after a retry interval, or latched until software clears it. For most sources it also selects whether the bridge is floated or braked.

The block keeps a sticky status bit per source and drives an active-low fault flag while any status bit is set. It sends the gate stage one of three commands: run, all gates low (Hi-Z), or low-side brake. When several faults are engaged at once, the worst command present wins. A single retry down-counter is loaded with the longest period among the pending retry faults, so drive resumes only after the slowest of them has expired. A clear-fault command wipes every status bit and releases every engaged fault. For the watchdog source, the block also raises a hold-reference or a fallback-reference request toward the speed control.

All detections and configuration arrive as plain synchronous levels and are sampled at each rising clock edge. Results appear on the outputs right after that edge. There is no data stream and no handshake: every pin is a plain control or status level.

Top module: `fault_resp_mgr`

## Requirements
- R1: Each lock source decodes its 3-bit mode as follows: 000 floats the bridge and latches; 001 and 010 brake and latch; 011 floats with retry; 100 and 101 brake with retry; 110 only reports and leaves the gates running; 111 ignores the source entirely.
- R2: The dry-run source decodes its 2-bit mode as follows: 00 ignores it; 01 only reports; 10 floats with retry; 11 floats and latches.
- R3: The CRC source floats and latches when its mode bit is 0, and only reports when it is 1. The watchdog source is set by a shutdown bit and a limp bit, written {shutdown,limp}. With 00 it only reports. With 01 it latches `ref_hold` and keeps the gates running. With 10 it floats and latches. With 11 it latches `ref_fallback` and keeps the gates running.
- R4: A supply source whose 3-bit threshold code is 000 is ignored. With a non-zero code it floats the bridge. With its auto bit at 0 it latches. With its auto bit at 1 it is released at the first edge that samples its in-band input high while its detect input is low.
- R5: A retry fault keeps its gate command until the P-th rising edge after the last edge that sampled any pending retry detection high, where P is the period loaded for that fault. A detection that reasserts during the countdown restarts it.
- R6: When several retry faults are pending, the countdown uses the largest period among them.
- R7: `gate_cmd` is 2'b00 for run, 2'b01 for Hi-Z and 2'b10 for brake. Hi-Z wins over brake and brake wins over run across all engaged sources. A latched fault keeps its command after a retry release.
- R8: `nfault` is low exactly while any status bit is set. A sampled detection sets the status bit of its source unless that source is ignored.
- R9: A `clr_flt` sampled high clears every status bit and releases every latched, retry, automatic and reference-hold condition at that edge. It takes precedence over detections sampled at the same edge.
- R10: At a retry release, the status bits of all sources in retry or report-only mode are cleared, unless that source's detection is sampled high at the same edge. Status bits of latched and supply-automatic sources are kept.
- R11: After reset, `gate_cmd` is 2'b00, `nfault` is 1, and all status bits and reference requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_det | input | N_LOCK | Lock and current-limit detections, one bit per source |
| lock_mode | input | 3*N_LOCK | 3-bit mode per lock source, source i at bits [3i+2:3i] |
| lock_per | input | CNT_W*N_LOCK | Retry period per lock source, in clock cycles |
| dry_det | input | 1 | Dry-run detection |
| dry_mode | input | 2 | Dry-run mode |
| dry_per | input | CNT_W | Dry-run retry period in clock cycles |
| crc_err | input | 1 | Bus CRC error detection |
| crc_mode | input | 1 | CRC response: 0 latch Hi-Z, 1 report only |
| wd_det | input | 1 | Watchdog timeout detection |
| wd_shut | input | 1 | Watchdog shutdown response bit |
| wd_limp | input | 1 | Watchdog limp bit |
| ov_det | input | 1 | Supply overvoltage detection |
| ov_code | input | 3 | Overvoltage threshold code, 000 disables |
| ov_auto | input | 1 | Overvoltage automatic recovery select |
| ov_inband | input | 1 | Supply back inside the overvoltage hysteresis band |
| uv_det | input | 1 | Supply undervoltage detection |
| uv_code | input | 3 | Undervoltage threshold code, 000 disables |
| uv_auto | input | 1 | Undervoltage automatic recovery select |
| uv_inband | input | 1 | Supply back inside the undervoltage hysteresis band |
| clr_flt | input | 1 | Clear-fault command |
| gate_cmd | output | 2 | Gate stage command: 00 run, 01 Hi-Z, 10 brake |
| nfault | output | 1 | Active-low fault flag |
| fault_stat | output | N_LOCK+5 | Sticky status: lock sources, dry-run, CRC, watchdog, overvoltage, undervoltage (LSB first) |
| ref_hold | output | 1 | Watchdog request to hold the present reference |
| ref_fallback | output | 1 | Watchdog request to use the fallback reference |

## Verification
The bench checks the release edge of a single retry fault exactly, and checks that a detection during the countdown restarts it. A design that counts from the first detection, or that releases one edge early or late, fails these checks. Two retry faults with short and long periods that drop together must hold until the long period ends; a design that keeps the period of whichever fault came last releases early. A latched brake fault mixed with a retry Hi-Z fault must fall back to brake after the retry release rather than to run, and its status bit must survive while the retry and report-only bits are wiped. The bench also covers disabled-threshold supply faults, automatic supply recovery gated by the in-band input, every watchdog combination, and a clear command that lands in the same cycle as a detection.

// File: rtl/frm_pkg.sv
package frm_pkg;
  typedef enum logic [2:0] {
    ACT_NONE   = 3'd0,
    ACT_REPORT = 3'd1,
    ACT_RETRY  = 3'd2,
    ACT_LATCH  = 3'd3,
    ACT_AUTO   = 3'd4
  } act_e;

  // values double as the gate stage command code
  typedef enum logic [1:0] {
    DRV_RUN   = 2'b00,
    DRV_HIZ   = 2'b01,
    DRV_BRAKE = 2'b10
  } drv_e;

  typedef struct packed {
    act_e act;
    drv_e drv;
  } pol_t;

  function automatic pol_t mk(input act_e a, input drv_e d);
    pol_t p;
    p.act = a;
    p.drv = d;
    return p;
  endfunction

  function automatic pol_t dec_lock(input logic [2:0] m);
    case (m)
      3'b000:         return mk(ACT_LATCH, DRV_HIZ);
      3'b001, 3'b010: return mk(ACT_LATCH, DRV_BRAKE);
      3'b011:         return mk(ACT_RETRY, DRV_HIZ);
      3'b100, 3'b101: return mk(ACT_RETRY, DRV_BRAKE);
      3'b110:         return mk(ACT_REPORT, DRV_RUN);
      default:        return mk(ACT_NONE, DRV_RUN);
    endcase
  endfunction

  function automatic pol_t dec_dry(input logic [1:0] m);
    case (m)
      2'b01:   return mk(ACT_REPORT, DRV_RUN);
      2'b10:   return mk(ACT_RETRY, DRV_HIZ);
      2'b11:   return mk(ACT_LATCH, DRV_HIZ);
      default: return mk(ACT_NONE, DRV_RUN);
    endcase
  endfunction

  function automatic pol_t dec_crc(input logic m);
    return m ? mk(ACT_REPORT, DRV_RUN) : mk(ACT_LATCH, DRV_HIZ);
  endfunction

  function automatic pol_t dec_wd(input logic shut, input logic limp);
    if (!shut && !limp) return mk(ACT_REPORT, DRV_RUN);
    if (shut && !limp)  return mk(ACT_LATCH, DRV_HIZ);
    return mk(ACT_LATCH, DRV_RUN);
  endfunction

  function automatic pol_t dec_sup(input logic [2:0] code, input logic auto_rec);
    if (code == 3'b000) return mk(ACT_NONE, DRV_RUN);
    return auto_rec ? mk(ACT_AUTO, DRV_HIZ) : mk(ACT_LATCH, DRV_HIZ);
  endfunction
endpackage

// File: rtl/frm_policy.sv
module frm_policy
  import frm_pkg::*;
#(
  parameter int N_LOCK = 3,
  parameter int NSRC   = N_LOCK + 5
) (
  input  logic [3*N_LOCK-1:0] lock_mode,
  input  logic [1:0]          dry_mode,
  input  logic                crc_mode,
  input  logic                wd_shut,
  input  logic                wd_limp,
  input  logic [2:0]          ov_code,
  input  logic                ov_auto,
  input  logic [2:0]          uv_code,
  input  logic                uv_auto,
  output pol_t [NSRC-1:0]     pol
);
  for (genvar g = 0; g < N_LOCK; g++) begin : g_lock
    assign pol[g] = dec_lock(lock_mode[3*g +: 3]);
  end
  assign pol[N_LOCK]   = dec_dry(dry_mode);
  assign pol[N_LOCK+1] = dec_crc(crc_mode);
  assign pol[N_LOCK+2] = dec_wd(wd_shut, wd_limp);
  assign pol[N_LOCK+3] = dec_sup(ov_code, ov_auto);
  assign pol[N_LOCK+4] = dec_sup(uv_code, uv_auto);
endmodule

// File: rtl/frm_src_bank.sv
module frm_src_bank
  import frm_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            rel,
  input  logic [NSRC-1:0] det,
  input  logic [NSRC-1:0] recover,
  input  pol_t [NSRC-1:0] pol,
  output logic [NSRC-1:0] stat,
  output logic [NSRC-1:0] lat,
  output logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] aut,
  output logic [NSRC-1:0] rdet
);
  logic [NSRC-1:0] v_set, v_lat, v_auto, v_relclr;

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      v_set[i]    = det[i] && (pol[i].act != ACT_NONE);
      v_lat[i]    = det[i] && (pol[i].act == ACT_LATCH);
      rdet[i]     = det[i] && (pol[i].act == ACT_RETRY);
      v_auto[i]   = det[i] && (pol[i].act == ACT_AUTO);
      v_relclr[i] = rel && ((pol[i].act == ACT_RETRY) || (pol[i].act == ACT_REPORT));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      lat  <= '0;
      pend <= '0;
      aut  <= '0;
    end else if (clr) begin
      stat <= '0;
      lat  <= '0;
      pend <= '0;
      aut  <= '0;
    end else begin
      stat <= (stat & ~v_relclr) | v_set;
      lat  <= lat | v_lat;
      pend <= (rel ? '0 : pend) | rdet;
      aut  <= (aut & ~recover) | v_auto;
    end
  end

  // R7: a latched source stays latched until a clear
  a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((lat & $past(lat)) == $past(lat)));

  // R9: clear wipes every held condition
  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (stat == '0 && lat == '0 && pend == '0 && aut == '0));

  // R5: a retry release leaves nothing pending
  a_r5_release_drops: assert property (@(posedge clk) disable iff (!rst_n)
    rel |=> (pend == '0));
endmodule

// File: rtl/frm_retry_timer.sv
module frm_retry_timer #(
  parameter int NSRC  = 8,
  parameter int NRET  = 4,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [NSRC-1:0]   rdet,
  input  logic [NSRC-1:0]   pend,
  input  logic [NRET*CNT_W-1:0] per,
  output logic              rel
);
  logic [CNT_W-1:0] cnt, maxp;
  logic any_r, any_p;

  always_comb begin
    maxp = '0;
    for (int i = 0; i < NRET; i++) begin
      if ((pend[i] || rdet[i]) && (per[i*CNT_W +: CNT_W] > maxp))
        maxp = per[i*CNT_W +: CNT_W];
    end
  end

  assign any_r = |rdet;
  assign any_p = |pend;
  assign rel   = any_p && !any_r && (cnt <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (any_r)    cnt <= maxp;
    else if (any_p)    cnt <= rel ? '0 : cnt - CNT_W'(1);
  end

  // R5: the countdown does not move while nothing is pending
  a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_p && !any_r && !clr) |=> $stable(cnt));
endmodule

// File: rtl/fault_resp_mgr.sv
module fault_resp_mgr
  import frm_pkg::*;
#(
  parameter int N_LOCK = 3,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_LOCK-1:0]       lock_det,
  input  logic [3*N_LOCK-1:0]     lock_mode,
  input  logic [CNT_W*N_LOCK-1:0] lock_per,
  input  logic                    dry_det,
  input  logic [1:0]              dry_mode,
  input  logic [CNT_W-1:0]        dry_per,
  input  logic                    crc_err,
  input  logic                    crc_mode,
  input  logic                    wd_det,
  input  logic                    wd_shut,
  input  logic                    wd_limp,
  input  logic                    ov_det,
  input  logic [2:0]              ov_code,
  input  logic                    ov_auto,
  input  logic                    ov_inband,
  input  logic                    uv_det,
  input  logic [2:0]              uv_code,
  input  logic                    uv_auto,
  input  logic                    uv_inband,
  input  logic                    clr_flt,
  output logic [1:0]              gate_cmd,
  output logic                    nfault,
  output logic [N_LOCK+4:0]       fault_stat,
  output logic                    ref_hold,
  output logic                    ref_fallback
);
  localparam int NSRC = N_LOCK + 5;
  localparam int NRET = N_LOCK + 1;
  localparam int I_WD = N_LOCK + 2;

  pol_t [NSRC-1:0] pol;
  logic [NSRC-1:0] det, recover, stat, lat, pend, aut, rdet, engaged;
  logic rel, any_hiz, any_brake;

  assign det     = {uv_det, ov_det, wd_det, crc_err, dry_det, lock_det};
  assign recover = {uv_inband & ~uv_det, ov_inband & ~ov_det, {(N_LOCK+3){1'b0}}};

  frm_policy #(.N_LOCK(N_LOCK), .NSRC(NSRC)) u_policy (
    .lock_mode(lock_mode), .dry_mode(dry_mode), .crc_mode(crc_mode),
    .wd_shut(wd_shut), .wd_limp(wd_limp),
    .ov_code(ov_code), .ov_auto(ov_auto),
    .uv_code(uv_code), .uv_auto(uv_auto),
    .pol(pol)
  );

  frm_src_bank #(.NSRC(NSRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(clr_flt), .rel(rel),
    .det(det), .recover(recover), .pol(pol),
    .stat(stat), .lat(lat), .pend(pend), .aut(aut), .rdet(rdet)
  );

  frm_retry_timer #(.NSRC(NSRC), .NRET(NRET), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(clr_flt),
    .rdet(rdet), .pend(pend), .per({dry_per, lock_per}),
    .rel(rel)
  );

  assign engaged = lat | pend | aut;

  always_comb begin
    any_hiz   = 1'b0;
    any_brake = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (engaged[i] && pol[i].drv == DRV_HIZ)   any_hiz   = 1'b1;
      if (engaged[i] && pol[i].drv == DRV_BRAKE) any_brake = 1'b1;
    end
  end

  assign gate_cmd     = any_hiz ? DRV_HIZ : (any_brake ? DRV_BRAKE : DRV_RUN);
  assign nfault       = ~|stat;
  assign fault_stat   = stat;
  assign ref_hold     = lat[I_WD] & ~wd_shut & wd_limp;
  assign ref_fallback = lat[I_WD] & wd_shut & wd_limp;

  // R7: only the three defined command codes appear
  a_r7_legal_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    gate_cmd != 2'b11);

  // R8: the gates are never taken over without a reported fault
  a_r8_drive_implies_report: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_cmd != 2'b00) |-> !nfault);
endmodule

// File: tb/fault_resp_mgr_tb_top.sv
module fault_resp_mgr_tb_top;
  localparam int NL = 3;
  localparam int W  = 8;
  localparam int NS = NL + 5;
  localparam int I_DRY = NL, I_CRC = NL + 1, I_WD = NL + 2, I_OV = NL + 3, I_UV = NL + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL-1:0] lock_det;
  logic [3*NL-1:0] lock_mode;
  logic [W*NL-1:0] lock_per;
  logic dry_det; logic [1:0] dry_mode; logic [W-1:0] dry_per;
  logic crc_err, crc_mode, wd_det, wd_shut, wd_limp;
  logic ov_det; logic [2:0] ov_code; logic ov_auto, ov_inband;
  logic uv_det; logic [2:0] uv_code; logic uv_auto, uv_inband;
  logic clr_flt;
  logic [1:0] gate_cmd; logic nfault; logic [NS-1:0] fault_stat;
  logic ref_hold, ref_fallback;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  bit [NS-1:0] ms, ml, mp, ma;
  int mcnt;

  always #2.5 clk = ~clk;

  fault_resp_mgr #(.N_LOCK(NL), .CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .lock_det(lock_det), .lock_mode(lock_mode), .lock_per(lock_per),
    .dry_det(dry_det), .dry_mode(dry_mode), .dry_per(dry_per),
    .crc_err(crc_err), .crc_mode(crc_mode), .wd_det(wd_det), .wd_shut(wd_shut), .wd_limp(wd_limp),
    .ov_det(ov_det), .ov_code(ov_code), .ov_auto(ov_auto), .ov_inband(ov_inband),
    .uv_det(uv_det), .uv_code(uv_code), .uv_auto(uv_auto), .uv_inband(uv_inband),
    .clr_flt(clr_flt), .gate_cmd(gate_cmd), .nfault(nfault), .fault_stat(fault_stat),
    .ref_hold(ref_hold), .ref_fallback(ref_fallback)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // act: 0 ignore, 1 report, 2 retry, 3 latch, 4 auto; drv: 0 run, 1 hiz, 2 brake
  function automatic void bpol(input int i, output int act, output int drv);
    act = 0; drv = 0;
    if (i < NL) begin
      case (lock_mode[3*i +: 3])
        3'd0: begin act = 3; drv = 1; end
        3'd1, 3'd2: begin act = 3; drv = 2; end
        3'd3: begin act = 2; drv = 1; end
        3'd4, 3'd5: begin act = 2; drv = 2; end
        3'd6: begin act = 1; drv = 0; end
        default: begin act = 0; drv = 0; end
      endcase
    end else if (i == I_DRY) begin
      case (dry_mode)
        2'd1: begin act = 1; drv = 0; end
        2'd2: begin act = 2; drv = 1; end
        2'd3: begin act = 3; drv = 1; end
        default: begin act = 0; drv = 0; end
      endcase
    end else if (i == I_CRC) begin
      if (crc_mode) begin act = 1; drv = 0; end else begin act = 3; drv = 1; end
    end else if (i == I_WD) begin
      if (!wd_shut && !wd_limp) begin act = 1; drv = 0; end
      else if (wd_shut && !wd_limp) begin act = 3; drv = 1; end
      else begin act = 3; drv = 0; end
    end else begin
      logic [2:0] c; logic a;
      c = (i == I_OV) ? ov_code : uv_code;
      a = (i == I_OV) ? ov_auto : uv_auto;
      if (c == 3'd0) begin act = 0; drv = 0; end
      else begin act = a ? 4 : 3; drv = 1; end
    end
  endfunction

  function automatic int per_of(input int i);
    return (i < NL) ? int'(lock_per[i*W +: W]) : int'(dry_per);
  endfunction

  task automatic model_step();
    bit [NS-1:0] d, rd, ns, nl, np, na;
    int act, drv, maxp;
    bit anyr, anyp, rel;
    d = {uv_det, ov_det, wd_det, crc_err, dry_det, lock_det};
    rd = '0; maxp = 0;
    for (int i = 0; i < NS; i++) begin
      bpol(i, act, drv);
      rd[i] = d[i] && act == 2;
    end
    for (int i = 0; i <= NL; i++)
      if ((mp[i] || rd[i]) && per_of(i) > maxp) maxp = per_of(i);
    anyr = |rd; anyp = |mp;
    rel = anyp && !anyr && (mcnt <= 1);
    if (clr_flt) begin
      ms = '0; ml = '0; mp = '0; ma = '0; mcnt = 0;
      return;
    end
    for (int i = 0; i < NS; i++) begin
      bit recv;
      bpol(i, act, drv);
      recv = (i == I_OV) ? (ov_inband && !ov_det) : (i == I_UV) ? (uv_inband && !uv_det) : 1'b0;
      ns[i] = (ms[i] && !(rel && (act == 1 || act == 2))) || (d[i] && act != 0);
      nl[i] = ml[i] || (d[i] && act == 3);
      np[i] = (mp[i] && !rel) || rd[i];
      na[i] = (ma[i] && !recv) || (d[i] && act == 4);
    end
    if (anyr) mcnt = maxp;
    else if (anyp) mcnt = rel ? 0 : mcnt - 1;
    ms = ns; ml = nl; mp = np; ma = na;
  endtask

  task automatic compare_model();
    int act, drv, eg;
    bit hz, br;
    hz = 0; br = 0;
    for (int i = 0; i < NS; i++) begin
      bpol(i, act, drv);
      if ((ml[i] || mp[i] || ma[i]) && drv == 1) hz = 1;
      if ((ml[i] || mp[i] || ma[i]) && drv == 2) br = 1;
    end
    eg = hz ? 1 : (br ? 2 : 0);
    chk("R7", "gate_cmd", int'(gate_cmd), eg);
    chk("R8", "nfault", int'(nfault), int'(ms == '0));
    chk("R10", "fault_stat", int'(fault_stat), int'(ms));
    chk("R3", "ref_hold/ref_fallback", int'({ref_hold, ref_fallback}),
        int'({ml[I_WD] && !wd_shut && wd_limp, ml[I_WD] && wd_shut && wd_limp}));
  endtask

  // apply the inputs set so far at the next edge, then sample halfway after it
  task automatic tick();
    model_step();
    @(negedge clk);
    compare_model();
  endtask

  task automatic set_idle();
    lock_det = '0; lock_mode = '1; lock_per = '0;
    dry_det = 0; dry_mode = 2'd0; dry_per = '0;
    crc_err = 0; crc_mode = 1; wd_det = 0; wd_shut = 0; wd_limp = 0;
    ov_det = 0; ov_code = 3'd0; ov_auto = 0; ov_inband = 0;
    uv_det = 0; uv_code = 3'd0; uv_auto = 0; uv_inband = 0;
    clr_flt = 0;
  endtask

  task automatic do_clear();
    clr_flt = 1; tick(); clr_flt = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    set_idle();
    ms = '0; ml = '0; mp = '0; ma = '0; mcnt = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11", "reset gate_cmd", int'(gate_cmd), 0);
    chk("R11", "reset nfault", int'(nfault), 1);
    chk("R11", "reset stat", int'(fault_stat), 0);
    chk("R11", "reset refs", int'({ref_hold, ref_fallback}), 0);

    // R5: single retry Hi-Z, period 4
    lock_mode[2:0] = 3'd3; lock_per[7:0] = 8'd4;
    lock_det = 3'b001; tick();
    chk("R1", "mode 011 floats", int'(gate_cmd), 1);
    chk("R8", "stat set", int'(fault_stat[0]), 1);
    lock_det = '0;
    for (int k = 1; k <= 3; k++) begin
      tick(); chk("R5", "still held in countdown", int'(gate_cmd), 1);
    end
    tick();
    chk("R5", "released on 4th edge", int'(gate_cmd), 0);
    chk("R10", "retry stat auto-cleared", int'(fault_stat), 0);

    // R5: reassert restarts the countdown
    lock_det = 3'b001; tick();
    lock_det = '0; tick(); tick();
    lock_det = 3'b001; tick();
    lock_det = '0;
    for (int k = 1; k <= 3; k++) begin
      tick(); chk("R5", "restarted countdown holds", int'(gate_cmd), 1);
    end
    tick(); chk("R5", "release after restart", int'(gate_cmd), 0);

    // R6 and R7: short Hi-Z retry plus long brake retry
    lock_mode[2:0] = 3'd3; lock_per[7:0] = 8'd3;
    lock_mode[5:3] = 3'd4; lock_per[15:8] = 8'd9;
    lock_det = 3'b011; tick();
    chk("R7", "Hi-Z beats brake", int'(gate_cmd), 1);
    lock_det = '0;
    for (int k = 1; k <= 8; k++) tick();
    chk("R6", "held until the longer period", int'(gate_cmd), 1);
    tick(); chk("R6", "released after the longer period", int'(gate_cmd), 0);

    // R1: brake retry with mode 101
    lock_mode[5:3] = 3'd5; lock_per[15:8] = 8'd2;
    lock_det = 3'b010; tick();
    chk("R1", "mode 101 brakes", int'(gate_cmd), 2);
    lock_det = '0; tick(); tick();
    chk("R1", "mode 101 retries", int'(gate_cmd), 0);

    // R7: latched brake survives a retry release
    lock_mode[2:0] = 3'd3; lock_per[7:0] = 8'd2; lock_mode[8:6] = 3'd1;
    lock_det = 3'b101; tick();
    chk("R7", "combined Hi-Z", int'(gate_cmd), 1);
    lock_det = '0; tick(); tick();
    chk("R7", "latched brake remains", int'(gate_cmd), 2);
    chk("R10", "latched stat kept", int'(fault_stat), 4);
    do_clear();
    chk("R9", "clear releases gate", int'(gate_cmd), 0);
    chk("R9", "clear wipes stat", int'(fault_stat), 0);
    chk("R9", "nfault high after clear", int'(nfault), 1);

    // R9: clear wins over a detection in the same cycle
    lock_mode[8:6] = 3'd0; lock_det = 3'b100; clr_flt = 1; tick(); clr_flt = 0;
    chk("R9", "clear beats same-cycle detect", int'(fault_stat), 0);
    lock_det = '0; lock_mode = '1;

    // R8: ignored source, then report only
    lock_mode[2:0] = 3'd7; lock_det = 3'b001; tick();
    chk("R8", "ignored source leaves nfault", int'(nfault), 1);
    lock_mode[2:0] = 3'd6; tick();
    chk("R8", "report only pulls nfault", int'(nfault), 0);
    chk("R1", "report only keeps run", int'(gate_cmd), 0);
    lock_det = '0; tick(); tick();
    chk("R8", "report stat sticky", int'(fault_stat[0]), 1);
    lock_mode[5:3] = 3'd3; lock_per[15:8] = 8'd1;
    lock_det = 3'b010; tick(); lock_det = '0; tick();
    chk("R10", "release clears report stat", int'(fault_stat), 0);
    lock_mode = '1;

    // R2: dry-run modes
    dry_mode = 2'd2; dry_per = 8'd2; dry_det = 1; tick();
    chk("R2", "dry 10 floats", int'(gate_cmd), 1);
    dry_det = 0; tick(); tick();
    chk("R2", "dry 10 retries", int'(gate_cmd), 0);
    chk("R10", "dry stat cleared", int'(fault_stat[I_DRY]), 0);
    dry_mode = 2'd3; dry_det = 1; tick(); dry_det = 0;
    for (int k = 0; k < 5; k++) tick();
    chk("R2", "dry 11 latches", int'(gate_cmd), 1);
    do_clear();
    dry_mode = 2'd0; dry_det = 1; tick();
    chk("R2", "dry 00 ignored", int'(nfault), 1);
    dry_mode = 2'd1; tick();
    chk("R2", "dry 01 reports", int'(nfault), 0);
    chk("R2", "dry 01 runs", int'(gate_cmd), 0);
    dry_det = 0; dry_mode = 2'd0; do_clear();

    // R3: watchdog and CRC
    wd_shut = 0; wd_limp = 1; wd_det = 1; tick(); wd_det = 0;
    chk("R3", "wd 01 hold", int'(ref_hold), 1);
    chk("R3", "wd 01 runs", int'(gate_cmd), 0);
    tick(); chk("R3", "wd hold latched", int'(ref_hold), 1);
    do_clear(); chk("R3", "hold cleared", int'(ref_hold), 0);
    wd_shut = 1; wd_limp = 1; wd_det = 1; tick(); wd_det = 0;
    chk("R3", "wd 11 fallback", int'(ref_fallback), 1);
    chk("R3", "wd 11 runs", int'(gate_cmd), 0);
    do_clear();
    wd_shut = 1; wd_limp = 0; wd_det = 1; tick(); wd_det = 0; tick();
    chk("R3", "wd 10 latches Hi-Z", int'(gate_cmd), 1);
    do_clear();
    wd_shut = 0; wd_limp = 0; wd_det = 1; tick(); wd_det = 0;
    chk("R3", "wd 00 reports", int'(nfault), 0);
    chk("R3", "wd 00 runs", int'(gate_cmd), 0);
    do_clear();
    crc_mode = 0; crc_err = 1; tick(); crc_err = 0; tick();
    chk("R3", "crc 0 latches Hi-Z", int'(gate_cmd), 1);
    do_clear();
    crc_mode = 1; crc_err = 1; tick(); crc_err = 0;
    chk("R3", "crc 1 reports", int'(nfault), 0);
    chk("R3", "crc 1 runs", int'(gate_cmd), 0);
    do_clear();

    // R4: supply faults
    ov_code = 3'd0; ov_det = 1; tick();
    chk("R4", "code 000 ignored", int'(nfault), 1);
    ov_code = 3'd3; ov_auto = 1; ov_inband = 0; tick();
    chk("R4", "ov floats", int'(gate_cmd), 1);
    ov_det = 0; tick();
    chk("R4", "no recovery outside band", int'(gate_cmd), 1);
    ov_inband = 1; tick();
    chk("R4", "auto recovery in band", int'(gate_cmd), 0);
    chk("R4", "auto stat sticky", int'(fault_stat[I_OV]), 1);
    do_clear(); ov_code = 3'd0; ov_inband = 0;
    uv_code = 3'd2; uv_auto = 0; uv_det = 1; tick();
    uv_det = 0; uv_inband = 1; tick(); tick();
    chk("R4", "latched uv ignores band", int'(gate_cmd), 1);
    do_clear(); set_idle(); tick();

    // constrained random phases against the bench model
    void'($urandom(32'h1357));
    for (int ph = 0; ph < 40; ph++) begin
      for (int i = 0; i < NL; i++) begin
        lock_mode[3*i +: 3] = 3'($urandom % 8);
        lock_per[W*i +: W] = W'(1 + $urandom % 12);
      end
      dry_mode = 2'($urandom % 4); dry_per = W'(1 + $urandom % 12);
      crc_mode = 1'($urandom % 2); wd_shut = 1'($urandom % 2); wd_limp = 1'($urandom % 2);
      ov_code = 3'($urandom % 4); ov_auto = 1'($urandom % 2);
      uv_code = 3'($urandom % 4); uv_auto = 1'($urandom % 2);
      do_clear();
      for (int c = 0; c < 300; c++) begin
        for (int i = 0; i < NL; i++) lock_det[i] = ($urandom % 100) < 4;
        dry_det = ($urandom % 100) < 3;
        crc_err = ($urandom % 100) < 1;
        wd_det  = ($urandom % 100) < 1;
        ov_det  = ($urandom % 100) < 2;
        uv_det  = ($urandom % 100) < 2;
        ov_inband = $urandom % 2; uv_inband = $urandom % 2;
        clr_flt = ($urandom % 100) < 1;
        tick();
      end
      set_idle();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule